// File: doc/BRIEF.md
# Serial LED Cascade Driver

The block keeps a 24-bit output image, made of three 8-bit groups, and shifts it over and over into an external chain of serial-in, parallel-out registers. Each frame ends with a latch strobe that moves the shifted bits to the parallel outputs. Software sets the image and the settings through a small write port. A 3-bit mask picks which groups belong to the chain. A control bit picks the shift-clock edge on which the external registers sample.

Hardware status lines can drive chosen image bits without software. These are two lines from a DSL modem and four 3-bit status groups from Ethernet PHYs. Each overridable bit has its own enable. A bit that is not overridden keeps the software value. The image and the settings are captured only when a frame starts, so each frame is shifted out as one consistent snapshot.

Top module: `serial_led_driver`

## Requirements
- R1: After reset the image equals the parameter SHADOW_INIT, the group mask is 0, the clock edge is falling, the divisor is 1 and every override is off. The outputs are idle: sclk high, sdo low, store low.
- R2: A frame shifts only the groups whose mask bit is set (mask bit g selects image bits 8g+7..8g). The highest enabled group goes first and each group goes MSB first, for 8 x popcount(mask) bits in total.
- R3: The store output is high for exactly one system cycle per frame. It rises D system cycles after the last sampling edge, where D is the effective divisor.
- R4: While the group mask is zero, no shift-clock edges and no store pulses appear, and sclk stays at its idle level.
- R5: With the rising bit set, sclk idles low and the external registers sample on its rising edge. With the bit clear, sclk idles high and they sample on its falling edge. sdo changes only while sclk is at its idle level.
- R6: Consecutive sampling edges within a frame are 2 x D system cycles apart. D is the divisor field, and a divisor of 0 counts as 1.
- R7: The DSL enable bit k (k = 0, 1) makes image bit k follow dsl_stat[k].
- R8: The PHY enable bit 3p+k (PHY p = 0..3, k = 0..2) makes image bit 2+3p+k follow phy_stat[3p+k]. Every bit without an enabled override carries the software value.
- R9: The image and the settings are captured at the start of a frame. A write made during a frame first shows in the next frame.
- R10: The write port decodes wr_sel as follows. 0 writes the software image. 1 writes control: mask [2:0], rising [3], DSL enables [5:4], divisor [15:8]. 2 writes the 12 PHY enables in bits [11:0]. A write with wr_sel of 3 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select |
| wr_data | input | 24 | Write data |
| dsl_stat | input | 2 | DSL status lines |
| phy_stat | input | 12 | PHY status lines, three per PHY |
| sdo | output | 1 | Serial data to the cascade |
| sclk | output | 1 | Shift clock to the cascade |
| store | output | 1 | Latch strobe to the cascade |

## Verification
The assertions depend on the outputs being registered and on the frame sequencer running from captured copies of the settings. Because of this they hold even when software rewrites the configuration in the middle of a frame. The content checks assume that the status lines and the settings stay stable for a whole frame before it is compared. The stimulus ensures this by changing them only between checks and then skipping one frame before it compares. The divisor is drawn from a small range so that every frame finishes well inside the wait limits.

// File: rtl/serial_led_pkg.sv
// Shared types and helpers for the serial LED cascade driver.
// Assumes nothing beyond IEEE 1800-2017 semantics.
package serial_led_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_STORE = 2'd2
    } frame_state_t;

    // Number of set bits in a small mask.
    function automatic int count_ones(input logic [7:0] v);
        int n;
        n = 0;
        for (int i = 0; i < 8; i++) n += int'(v[i]);
        return n;
    endfunction

endpackage

// File: rtl/serial_led_regs.sv
// Configuration registers behind a simple select/data write port.
// Assumes the default field layout fits in the write data width.
module serial_led_regs #(
    parameter int GROUPS   = 3,
    parameter int GW       = 8,
    parameter int DSL_BITS = 2,
    parameter int N_PHY    = 4,
    parameter int PHY_BITS = 3,
    parameter int DIV_W    = 8,
    parameter logic [GROUPS*GW-1:0] SHADOW_INIT = '0,
    localparam int IMG_W   = GROUPS*GW,
    localparam int PHY_W   = N_PHY*PHY_BITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [IMG_W-1:0]  wr_data,
    output logic [IMG_W-1:0]  image_o,
    output logic [GROUPS-1:0] mask_o,
    output logic              rising_o,
    output logic [DSL_BITS-1:0] dsl_en_o,
    output logic [DIV_W-1:0]  div_o,
    output logic [PHY_W-1:0]  phy_en_o
);
    localparam int RISE_POS = GROUPS;
    localparam int DSL_POS  = GROUPS + 1;
    localparam int DIV_POS  = 8;

    // Register update on reset or a decoded write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            image_o  <= SHADOW_INIT;
            mask_o   <= '0;
            rising_o <= 1'b0;
            dsl_en_o <= '0;
            div_o    <= DIV_W'(1);
            phy_en_o <= '0;
        end else if (wr_en) begin
            case (wr_sel)
                2'd0: image_o <= wr_data;
                2'd1: begin
                    mask_o   <= wr_data[GROUPS-1:0];
                    rising_o <= wr_data[RISE_POS];
                    dsl_en_o <= wr_data[DSL_POS +: DSL_BITS];
                    div_o    <= wr_data[DIV_POS +: DIV_W];
                end
                2'd2: phy_en_o <= wr_data[PHY_W-1:0];
                default: ;
            endcase
        end
    end

    assert_sel3_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 2'd3) |=> ($stable(image_o) && $stable(mask_o) && $stable(phy_en_o)
                                       && $stable(div_o) && $stable(dsl_en_o) && $stable(rising_o)));
endmodule

// File: rtl/serial_led_merge.sv
// Merges hardware status overrides into the software image, bit by bit.
// Assumes DSL bits sit at the bottom and PHY fields follow in order.
module serial_led_merge #(
    parameter int GROUPS   = 3,
    parameter int GW       = 8,
    parameter int DSL_BITS = 2,
    parameter int N_PHY    = 4,
    parameter int PHY_BITS = 3,
    localparam int IMG_W   = GROUPS*GW,
    localparam int OVR_W   = DSL_BITS + N_PHY*PHY_BITS
) (
    input  logic [IMG_W-1:0]            sw_img_i,
    input  logic [DSL_BITS-1:0]         dsl_en_i,
    input  logic [DSL_BITS-1:0]         dsl_stat_i,
    input  logic [N_PHY*PHY_BITS-1:0]   phy_en_i,
    input  logic [N_PHY*PHY_BITS-1:0]   phy_stat_i,
    output logic [IMG_W-1:0]            img_o
);
    logic [OVR_W-1:0] ovr_en;
    logic [OVR_W-1:0] ovr_val;

    // Collect enables and status values in image bit order.
    always_comb begin
        ovr_en  = {phy_en_i, dsl_en_i};
        ovr_val = {phy_stat_i, dsl_stat_i};
    end

    for (genvar i = 0; i < IMG_W; i++) begin : g_bit
        if (i < OVR_W) begin : g_ovr
            assign img_o[i] = ovr_en[i] ? ovr_val[i] : sw_img_i[i];
        end else begin : g_sw
            assign img_o[i] = sw_img_i[i];
        end
    end
endmodule

// File: rtl/serial_led_shift.sv
// Frame sequencer: packs enabled groups, shifts them MSB first with a
// divided shift clock, then issues a one-cycle store strobe.
// Assumes inputs are synchronous; they are sampled only at frame start.
module serial_led_shift
    import serial_led_pkg::*;
#(
    parameter int GROUPS = 3,
    parameter int GW     = 8,
    parameter int DIV_W  = 8,
    localparam int IMG_W = GROUPS*GW,
    localparam int CNT_W = $clog2(IMG_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [GROUPS-1:0] mask_i,
    input  logic              rising_i,
    input  logic [DIV_W-1:0]  div_i,
    input  logic [IMG_W-1:0]  image_i,
    output logic              sdo_o,
    output logic              sclk_o,
    output logic              store_o
);
    frame_state_t     st_q;
    logic [IMG_W-1:0] packed_img;
    logic [IMG_W-1:0] sh_q;
    logic [CNT_W-1:0] n_bits;
    logic [CNT_W-1:0] left_q;
    logic [DIV_W-1:0] div_eff;
    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] cnt_q;
    logic             phase_q;
    logic             pol_q;
    logic             sdo_q;
    logic             sclk_q;
    logic             store_q;
    logic             tick;

    // Pack enabled groups MSB-aligned, highest group first.
    always_comb begin
        int fill;
        packed_img = '0;
        fill = 0;
        for (int g = GROUPS-1; g >= 0; g--) begin
            if (mask_i[g]) begin
                packed_img[IMG_W-1-fill*GW -: GW] = image_i[g*GW +: GW];
                fill++;
            end
        end
        n_bits  = CNT_W'(count_ones(8'(mask_i)) * GW);
        div_eff = (div_i == '0) ? DIV_W'(1) : div_i;
    end

    // Half-period tick from the captured divisor.
    assign tick = (cnt_q == div_q - DIV_W'(1));

    // Frame sequencing, shift clock and data generation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= ST_IDLE;
            sh_q    <= '0;
            left_q  <= '0;
            div_q   <= DIV_W'(1);
            cnt_q   <= '0;
            phase_q <= 1'b0;
            pol_q   <= 1'b0;
            sdo_q   <= 1'b0;
            sclk_q  <= 1'b1;
            store_q <= 1'b0;
        end else begin
            case (st_q)
                ST_IDLE: begin
                    store_q <= 1'b0;
                    sclk_q  <= ~rising_i;
                    if (mask_i != '0) begin
                        sh_q    <= packed_img;
                        left_q  <= n_bits;
                        div_q   <= div_eff;
                        pol_q   <= rising_i;
                        cnt_q   <= '0;
                        phase_q <= 1'b0;
                        sdo_q   <= packed_img[IMG_W-1];
                        st_q    <= ST_SHIFT;
                    end
                end
                ST_SHIFT: begin
                    if (!tick) begin
                        cnt_q <= cnt_q + DIV_W'(1);
                    end else begin
                        cnt_q <= '0;
                        if (!phase_q) begin
                            phase_q <= 1'b1;
                            sclk_q  <= pol_q;
                        end else begin
                            phase_q <= 1'b0;
                            sclk_q  <= ~pol_q;
                            if (left_q == CNT_W'(1)) begin
                                sdo_q   <= 1'b0;
                                store_q <= 1'b1;
                                st_q    <= ST_STORE;
                            end else begin
                                sh_q   <= sh_q << 1;
                                sdo_q  <= sh_q[IMG_W-2];
                                left_q <= left_q - CNT_W'(1);
                            end
                        end
                    end
                end
                default: begin
                    store_q <= 1'b0;
                    st_q    <= ST_IDLE;
                end
            endcase
        end
    end

    assign sdo_o   = sdo_q;
    assign sclk_o  = sclk_q;
    assign store_o = store_q;

    assert_store_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        store_q |=> !store_q);
    assert_idle_when_masked_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_IDLE && mask_i == '0) |=> (st_q == ST_IDLE && !store_q));
    assert_sdo_moves_at_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sdo_q) |-> (sclk_q == ~pol_q));
    assert_sclk_idle_at_store_R3: assert property (@(posedge clk) disable iff (!rst_n)
        store_q |-> (sclk_q == ~pol_q));
    assert_bits_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_SHIFT) |-> (left_q != '0 && left_q <= CNT_W'(IMG_W)));
endmodule

// File: rtl/serial_led_driver.sv
// Top level: registers, override merge and frame sequencer.
// Assumes status inputs are already synchronous to clk.
module serial_led_driver #(
    parameter int GROUPS   = 3,
    parameter int GW       = 8,
    parameter int DSL_BITS = 2,
    parameter int N_PHY    = 4,
    parameter int PHY_BITS = 3,
    parameter int DIV_W    = 8,
    parameter logic [GROUPS*GW-1:0] SHADOW_INIT = 24'hA5C3F0,
    localparam int IMG_W   = GROUPS*GW,
    localparam int PHY_W   = N_PHY*PHY_BITS
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [1:0]          wr_sel,
    input  logic [IMG_W-1:0]    wr_data,
    input  logic [DSL_BITS-1:0] dsl_stat,
    input  logic [PHY_W-1:0]    phy_stat,
    output logic                sdo,
    output logic                sclk,
    output logic                store
);
    logic [IMG_W-1:0]    sw_img;
    logic [IMG_W-1:0]    eff_img;
    logic [GROUPS-1:0]   mask;
    logic                rising;
    logic [DSL_BITS-1:0] dsl_en;
    logic [DIV_W-1:0]    div;
    logic [PHY_W-1:0]    phy_en;

    serial_led_regs #(
        .GROUPS(GROUPS), .GW(GW), .DSL_BITS(DSL_BITS), .N_PHY(N_PHY),
        .PHY_BITS(PHY_BITS), .DIV_W(DIV_W), .SHADOW_INIT(SHADOW_INIT)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .image_o(sw_img), .mask_o(mask), .rising_o(rising), .dsl_en_o(dsl_en),
        .div_o(div), .phy_en_o(phy_en)
    );

    serial_led_merge #(
        .GROUPS(GROUPS), .GW(GW), .DSL_BITS(DSL_BITS), .N_PHY(N_PHY), .PHY_BITS(PHY_BITS)
    ) u_merge (
        .sw_img_i(sw_img), .dsl_en_i(dsl_en), .dsl_stat_i(dsl_stat),
        .phy_en_i(phy_en), .phy_stat_i(phy_stat), .img_o(eff_img)
    );

    serial_led_shift #(
        .GROUPS(GROUPS), .GW(GW), .DIV_W(DIV_W)
    ) u_shift (
        .clk(clk), .rst_n(rst_n), .mask_i(mask), .rising_i(rising), .div_i(div),
        .image_i(eff_img), .sdo_o(sdo), .sclk_o(sclk), .store_o(store)
    );
endmodule

// File: tb/test_serial_led_driver.sv
module test_serial_led_driver;
    localparam int CLK_PERIOD = 10;
    localparam logic [23:0] SHADOW = 24'hA5C3F0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = '0;
    logic [23:0] wr_data = '0;
    logic [1:0]  dsl_stat = '0;
    logic [11:0] phy_stat = '0;
    logic        sdo, sclk, store;

    serial_led_driver #(.SHADOW_INIT(SHADOW)) i_serial_led_driver (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .dsl_stat(dsl_stat), .phy_stat(phy_stat), .sdo(sdo), .sclk(sclk), .store(store)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Bench model of the registers
    logic [23:0] m_img = SHADOW;
    logic [2:0]  m_mask = '0;
    logic        m_rising = 1'b0;
    logic [1:0]  m_dsl_en = '0;
    logic [7:0]  m_div = 8'd1;
    logic [11:0] m_phy_en = '0;

    int compared = 0, mismatched = 0;

    // Monitor state
    int cyc = 0, n_bits = 0, sp_err = 0, last_s = 0, frames = 0, edges = 0, stores = 0, dbl = 0;
    logic [23:0] cap = '0;
    logic prev_sclk = 1'b1, prev_store = 1'b0;
    int f_n = 0, f_sp = 0, f_gap = 0;
    logic [23:0] f_cap = '0;
    logic f_sclk = 1'b0;

    function automatic int d_eff();
        return (m_div == 0) ? 1 : int'(m_div);
    endfunction

    function automatic logic [23:0] exp_image();
        logic [23:0] v;
        v = m_img;
        for (int k = 0; k < 2; k++) if (m_dsl_en[k]) v[k] = dsl_stat[k];
        for (int j = 0; j < 12; j++) if (m_phy_en[j]) v[2+j] = phy_stat[j];
        return v;
    endfunction

    function automatic logic [23:0] exp_bits(input logic [23:0] img);
        logic [23:0] r;
        r = '0;
        for (int g = 2; g >= 0; g--) if (m_mask[g]) r = {r[15:0], img[g*8 +: 8]};
        return r;
    endfunction

    function automatic int exp_count();
        int c;
        c = 0;
        for (int g = 0; g < 3; g++) if (m_mask[g]) c += 8;
        return c;
    endfunction

    always @(negedge clk) begin
        cyc++;
        if (!rst_n) begin
            n_bits = 0; sp_err = 0; cap = '0;
        end else begin
            if (sclk !== prev_sclk) begin
                edges++;
                if (sclk === m_rising) begin
                    cap = {cap[22:0], sdo};
                    n_bits++;
                    if (n_bits > 1 && (cyc - last_s) != 2*d_eff()) sp_err++;
                    last_s = cyc;
                end
            end
            if (store === 1'b1) begin
                if (prev_store === 1'b1) dbl++;
                f_n = n_bits; f_cap = cap; f_sp = sp_err; f_gap = cyc - last_s; f_sclk = sclk;
                frames++; stores++;
                n_bits = 0; sp_err = 0; cap = '0;
            end
        end
        prev_sclk = sclk;
        prev_store = store;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [23:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        case (sel)
            2'd0: m_img = d;
            2'd1: begin m_mask = d[2:0]; m_rising = d[3]; m_dsl_en = d[5:4]; m_div = d[15:8]; end
            2'd2: m_phy_en = d[11:0];
            default: ;
        endcase
    endtask

    task automatic wait_frames(input int k);
        int f0, t0;
        f0 = frames; t0 = cyc;
        while (frames < f0 + k && cyc - t0 < 5000) @(negedge clk);
        if (frames < f0 + k) check(1'b0, "WDOG", "frame timeout", 32'(frames), 32'(f0 + k));
    endtask

    task automatic check_frame(input string req, input logic [23:0] img);
        check(f_cap == exp_bits(img), req, "frame bits", 32'(f_cap), 32'(exp_bits(img)));
        check(f_n == exp_count(), "R2", "bit count", 32'(f_n), 32'(exp_count()));
        check(f_sp == 0, "R6", "edge spacing errors", 32'(f_sp), 0);
        check(f_gap == d_eff(), "R3", "last edge to store gap", 32'(f_gap), 32'(d_eff()));
        check(f_sclk == ~m_rising, "R5", "sclk idle level at store", 32'(f_sclk), 32'(~m_rising));
    endtask

    initial begin
        logic [23:0] img_a;
        int e0, s0;
        void'($urandom(32'd1234));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: idle outputs after reset
        check(sclk === 1'b1, "R1", "sclk after reset", 32'(sclk), 1);
        check(sdo === 1'b0, "R1", "sdo after reset", 32'(sdo), 0);
        check(store === 1'b0, "R1", "store after reset", 32'(store), 0);
        // R1: shadow image shifted once groups are enabled
        wr(2'd1, 24'h000107);
        wait_frames(2);
        check_frame("R1", exp_image());

        // R6: divisor 0 behaves as 1
        wr(2'd1, 24'h000005);
        wait_frames(2);
        check_frame("R6", exp_image());

        // R5: rising mode, R7/R8 directed all-override
        dsl_stat = 2'b10; phy_stat = 12'hA5C;
        wr(2'd2, 24'h000FFF);
        wr(2'd1, 24'h00023F);
        wait_frames(2);
        check_frame("R8", exp_image());

        // Random mix covering R2, R5, R6, R7, R8
        for (int it = 0; it < 30; it++) begin
            dsl_stat = 2'($urandom);
            phy_stat = 12'($urandom);
            wr(2'd0, 24'($urandom));
            wr(2'd2, 24'($urandom));
            wr(2'd1, {8'h00, 8'($urandom_range(0, 5)), 2'b00, 2'($urandom), 1'($urandom),
                      3'($urandom_range(1, 7))});
            wait_frames(2);
            check_frame("R7", exp_image());
        end

        // R9: a write during a frame shows in the next frame only
        wr(2'd2, 24'h0);
        wr(2'd1, 24'h000307);
        wr(2'd0, 24'h3C96E1);
        wait_frames(2);
        img_a = exp_image();
        wait_frames(1);
        repeat (10) @(negedge clk);
        wr(2'd0, 24'h5A0F81);
        wait_frames(1);
        check(f_cap == exp_bits(img_a), "R9", "frame during write", 32'(f_cap), 32'(exp_bits(img_a)));
        wait_frames(1);
        check(f_cap == exp_bits(exp_image()), "R9", "frame after write", 32'(f_cap), 32'(exp_bits(exp_image())));

        // R10: select 3 is ignored
        wr(2'd3, 24'hFFFFFF);
        wait_frames(2);
        check_frame("R10", exp_image());

        // R3: never two store cycles in a row
        check(dbl == 0, "R3", "double-cycle store", 32'(dbl), 0);

        // R4: mask zero stops everything
        wr(2'd1, 24'h000308);
        repeat (600) @(negedge clk);
        e0 = edges; s0 = stores;
        repeat (400) @(negedge clk);
        check(edges == e0, "R4", "sclk edges while masked", 32'(edges - e0), 0);
        check(stores == s0, "R4", "stores while masked", 32'(stores - s0), 0);
        check(sclk === 1'b0, "R4", "sclk idle level while masked", 32'(sclk), 0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule